// File: doc/BRIEF.md
# Packet Buffer Line Sequencer

This controller sits between a single-port line RAM (512 lines of 32 bits, one cycle of read latency) and two streaming ports: an ingress port that accepts words to be stored and an egress port that hands stored words to a consumer. A 32-bit command word qualified by a one-cycle `cmd_go` strobe tells the block to clear, to play a range of lines out as one packet, or to capture one incoming packet into a range of lines. The block drives the RAM enable, write enable, address and write data, and takes the RAM read data back in.

A range is given by a start line, an end line and a stride. It is inclusive at both ends and may wrap from the top line back to line 0. On playback the first word carries a start-of-packet tag and the last word an end-of-packet tag. A small prefetch queue covers the RAM latency, so a consumer that takes a word on every cycle sees no gaps. On capture the block stores each accepted word at the next line. It stops when the end line is stored or when a word carries an end-of-packet tag. A word that carries both tags anywhere except the first position aborts the capture with an error. Status stays visible until the next accepted command.

Top module: `pktbuf_seq`

## Requirements
- R1: `cmd_word` fields are: start line in bits 8:0, end line in bits 17:9, stride in bits 21:18, playback in bit 22, capture in bit 23, clear in bit 24. A `cmd_go` pulse acts on them with the priority clear, then capture, then playback.
- R2: An operation touches the lines start + k*stride (mod 512) for k = 0 .. floor(((end - start) mod 512) / stride). The count therefore includes both ends and wraps past line 511 to line 0.
- R3: A stride of 0 behaves as a stride of 1.
- R4: On `out_flags`, bit 0 is high only on the first word of a playback and bit 1 only on the last. Bits 3:2 are always 0.
- R5: A word is consumed only on a cycle where `out_read` and `out_ready` are both high. Until then `out_data` and `out_flags` hold their value.
- R6: When the consumer reads on every cycle, `out_ready` stays high from the first word to the last.
- R7: After the last playback word is taken, `op_done` is high and `out_ready` is low. `op_done` then holds until the next `cmd_go`.
- R8: During a capture `in_ready` is high. Each word accepted with `in_write` is written to the current line. Storing the end line raises `op_done` and drops `in_ready`.
- R9: A captured word with `in_flags` bit 1 (end of packet) set is stored and ends the capture with `op_done`, even before the end line is reached.
- R10: A captured word other than the first with both `in_flags` bit 0 and bit 1 set is not stored. It raises `op_error`, leaves `op_done` low and drops `in_ready`.
- R11: A clear command returns the block to idle, with `op_done`, `op_error`, `in_ready` and `out_ready` low.
- R12: A `cmd_go` with none of the clear, capture or playback bits set leaves the block and its status unchanged.
- R13: While `rst_n` is low and after it is released, `op_done`, `op_error`, `in_ready`, `out_ready` and `ram_en` are low.
- R14: `ram_we` is high only on a cycle where a capture word is accepted and stored. The number of RAM writes equals the number of words stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_word | input | 32 | Command: range, stride and operation bits |
| cmd_go | input | 1 | One-cycle strobe that acts on `cmd_word` |
| op_done | output | 1 | Operation finished normally |
| op_error | output | 1 | Capture aborted on a misplaced tag pair |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 9 | RAM line address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after the access |
| in_data | input | 32 | Ingress word |
| in_flags | input | 4 | Ingress tags: bit 0 start, bit 1 end of packet |
| in_write | input | 1 | Ingress word offered |
| in_ready | output | 1 | Block accepts an ingress word |
| out_data | output | 32 | Egress word |
| out_flags | output | 4 | Egress tags: bit 0 start, bit 1 end of packet |
| out_ready | output | 1 | Egress word available |
| out_read | input | 1 | Consumer takes the egress word |

## Verification
The bound checker verifies the cycle-level rules on every cycle:
- RAM writes occur only on accepted capture words.
- An egress word held against a stalled consumer stays stable.
- The ready signal stays unbroken under back-to-back reads.
- Done holds until the next go.
- Clear empties the status.
- An error state closes both ports.

Only the bench scenarios can show the following:
- The line sequence, including wraparound and strides.
- The word count of each range.
- Which lines a capture touches and which neighbours it leaves alone.
- Early termination on an end tag.
- Command priority.
- That an empty command is ignored.

// File: rtl/pktbuf_pkg.sv
// Shared types for the packet buffer line sequencer.
// Assumes: tags travel as a two-bit pair, end in bit 1 and start in bit 0.
package pktbuf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAY,
        ST_CAPT,
        ST_DONE,
        ST_FAULT
    } seq_state_t;

    typedef struct packed {
        logic eop;
        logic sop;
    } pkt_tag_t;

endpackage

// File: rtl/pktbuf_lines.sv
// Line address walker: keeps the current line, the distance left to the
// end line and the stride, and advances one stride per moved word.
// Assumes: stride is narrower than the address; stride 0 is taken as 1.
module pktbuf_lines #(
    parameter int ADDR_W = 9,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_first,
    input  logic [ADDR_W-1:0] ld_last,
    input  logic [STEP_W-1:0] ld_step,
    input  logic              adv,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              at_last,
    output logic              is_first,
    output logic              more
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] rem_q;
    logic [ADDR_W-1:0] step_q;
    logic              first_q;
    logic              more_q;

    // Final line of the range once the remaining distance is under one stride.
    assign at_last  = rem_q < step_q;
    assign cur_addr = addr_q;
    assign is_first = first_q;
    assign more     = more_q;

    // Load a new range or step forward through the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rem_q   <= '0;
            step_q  <= ADDR_W'(1);
            first_q <= 1'b0;
            more_q  <= 1'b0;
        end else if (load) begin
            addr_q  <= ld_first;
            rem_q   <= ld_last - ld_first;
            step_q  <= (ld_step == '0) ? ADDR_W'(1) : ADDR_W'(ld_step);
            first_q <= 1'b1;
            more_q  <= 1'b1;
        end else if (adv) begin
            first_q <= 1'b0;
            if (at_last) begin
                more_q <= 1'b0;
            end else begin
                addr_q <= addr_q + step_q;
                rem_q  <= rem_q - step_q;
            end
        end
    end

endmodule

// File: rtl/pktbuf_rdq.sv
// Playback prefetch queue: tracks one RAM read in flight and holds up to
// DEPTH returned words with their tags, presenting the oldest at the head.
// Assumes: the RAM returns data exactly one cycle after the read access, and
// pop is only raised while head_valid is high.
module pktbuf_rdq
    import pktbuf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              issue,
    input  pkt_tag_t          issue_tag,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [FLAG_W-1:0] head_flags,
    output logic              head_valid,
    output logic              credit
);

    localparam int DEPTH = 2;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] q_data [DEPTH];
    pkt_tag_t          q_tag  [DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic              pend;
    pkt_tag_t          pend_tag;
    logic [CNT_W:0]    occ_next;
    logic [CNT_W-1:0]  fill_slot;

    // Occupancy after this cycle, counting the word that is in flight.
    assign occ_next  = (CNT_W+1)'(cnt) + (CNT_W+1)'(pend) - (CNT_W+1)'(pop);
    assign credit    = occ_next < (CNT_W+1)'(DEPTH);
    assign fill_slot = cnt - CNT_W'(pop);

    assign head_valid = cnt != '0;
    assign head_data  = q_data[0];
    assign head_flags = {{(FLAG_W-2){1'b0}}, q_tag[0]};

    // Track the in-flight read and the number of words held.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt      <= '0;
            pend     <= 1'b0;
            pend_tag <= '0;
        end else begin
            pend     <= issue;
            pend_tag <= issue_tag;
            cnt      <= cnt + CNT_W'(pend) - CNT_W'(pop);
        end
    end

    // Shift out the head on pop and drop the returned word into the next free slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (pop && i < DEPTH - 1) begin
                q_data[i] <= q_data[(i + 1) % DEPTH];
                q_tag[i]  <= q_tag[(i + 1) % DEPTH];
            end
            if (pend && fill_slot == CNT_W'(i)) begin
                q_data[i] <= ram_rdata;
                q_tag[i]  <= pend_tag;
            end
        end
    end

endmodule

// File: rtl/pktbuf_ctrl.sv
// Operation state machine: takes commands, tracks playback and capture to
// completion, and records normal completion or a capture fault.
// Assumes: go_acc is already qualified by at least one operation bit.
module pktbuf_ctrl
    import pktbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_acc,
    input  logic       cmd_clr,
    input  logic       cmd_capt,
    input  logic       capt_acc,
    input  logic       capt_bad,
    input  logic       capt_eop,
    input  logic       at_last,
    input  logic       play_last_pop,
    output seq_state_t state
);

    seq_state_t state_nx;

    // Next-state choice; a new command overrides any ongoing operation.
    always_comb begin
        state_nx = state;
        if (go_acc) begin
            if (cmd_clr)       state_nx = ST_IDLE;
            else if (cmd_capt) state_nx = ST_CAPT;
            else               state_nx = ST_PLAY;
        end else begin
            unique case (state)
                ST_PLAY: if (play_last_pop) state_nx = ST_DONE;
                ST_CAPT: begin
                    if (capt_acc) begin
                        if (capt_bad)                 state_nx = ST_FAULT;
                        else if (capt_eop || at_last) state_nx = ST_DONE;
                    end
                end
                default: state_nx = state;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/pktbuf_seq.sv
// Packet buffer line sequencer top: decodes the command word, walks a line
// range with stride and wraparound, plays lines out through a prefetch
// queue or captures an incoming packet into lines.
// Assumes: single-port RAM with one cycle of read latency; CMD_W is wide
// enough for two addresses, the stride and three operation bits.
module pktbuf_seq
    import pktbuf_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    parameter int STEP_W = 4,
    parameter int FLAG_W = 4,
    parameter int CMD_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              cmd_go,
    output logic              op_done,
    output logic              op_error,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] in_data,
    input  logic [FLAG_W-1:0] in_flags,
    input  logic              in_write,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [FLAG_W-1:0] out_flags,
    output logic              out_ready,
    input  logic              out_read
);

    localparam int LAST_LSB = ADDR_W;
    localparam int STEP_LSB = 2 * ADDR_W;
    localparam int PLAY_POS = STEP_LSB + STEP_W;
    localparam int CAPT_POS = PLAY_POS + 1;
    localparam int CLR_POS  = PLAY_POS + 2;

    seq_state_t        state;
    logic              cmd_play, cmd_capt, cmd_clr, go_acc, start;
    logic [ADDR_W-1:0] cur_addr;
    logic              at_last, is_first, more;
    logic              capt_acc, capt_bad, capt_store, fetch, credit, pop;
    pkt_tag_t          fetch_tag;

    // Command decode.
    assign cmd_play = cmd_word[PLAY_POS];
    assign cmd_capt = cmd_word[CAPT_POS];
    assign cmd_clr  = cmd_word[CLR_POS];
    assign go_acc   = cmd_go && (cmd_play || cmd_capt || cmd_clr);
    assign start    = go_acc && !cmd_clr;

    // Capture side: accept, detect a misplaced tag pair, store.
    assign in_ready   = state == ST_CAPT;
    assign capt_acc   = in_write && in_ready && !go_acc;
    assign capt_bad   = in_flags[0] && in_flags[1] && !is_first;
    assign capt_store = capt_acc && !capt_bad;

    // Playback side: fetch when lines remain and the queue has room.
    assign fetch         = (state == ST_PLAY) && more && credit && !go_acc;
    assign fetch_tag.sop = is_first;
    assign fetch_tag.eop = at_last;
    assign pop           = out_read && out_ready;

    // RAM port.
    assign ram_en    = fetch || capt_store;
    assign ram_we    = capt_store;
    assign ram_addr  = cur_addr;
    assign ram_wdata = in_data;

    assign op_done  = state == ST_DONE;
    assign op_error = state == ST_FAULT;

    pktbuf_lines #(
        .ADDR_W (ADDR_W),
        .STEP_W (STEP_W)
    ) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .ld_first (cmd_word[ADDR_W-1:0]),
        .ld_last  (cmd_word[LAST_LSB +: ADDR_W]),
        .ld_step  (cmd_word[STEP_LSB +: STEP_W]),
        .adv      (fetch || capt_store),
        .cur_addr (cur_addr),
        .at_last  (at_last),
        .is_first (is_first),
        .more     (more)
    );

    pktbuf_rdq #(
        .DATA_W (DATA_W),
        .FLAG_W (FLAG_W)
    ) u_rdq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (go_acc),
        .issue      (fetch),
        .issue_tag  (fetch_tag),
        .ram_rdata  (ram_rdata),
        .pop        (pop),
        .head_data  (out_data),
        .head_flags (out_flags),
        .head_valid (out_ready),
        .credit     (credit)
    );

    pktbuf_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .go_acc        (go_acc),
        .cmd_clr       (cmd_clr),
        .cmd_capt      (cmd_capt),
        .capt_acc      (capt_acc),
        .capt_bad      (capt_bad),
        .capt_eop      (in_flags[1]),
        .at_last       (at_last),
        .play_last_pop (pop && out_flags[1]),
        .state         (state)
    );

endmodule

// File: rtl/pktbuf_seq_chk.sv
// Cycle-level rule checker for the packet buffer line sequencer, attached
// to every instance of the top module by bind.
module pktbuf_seq_chk #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    parameter int STEP_W = 4,
    parameter int FLAG_W = 4,
    parameter int CMD_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CMD_W-1:0]  cmd_word,
    input logic              cmd_go,
    input logic              op_done,
    input logic              op_error,
    input logic              ram_en,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DATA_W-1:0] ram_wdata,
    input logic [DATA_W-1:0] ram_rdata,
    input logic [DATA_W-1:0] in_data,
    input logic [FLAG_W-1:0] in_flags,
    input logic              in_write,
    input logic              in_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [FLAG_W-1:0] out_flags,
    input logic              out_ready,
    input logic              out_read
);

    localparam int CLR_POS = 2 * ADDR_W + STEP_W + 2;

    assert_we_on_accept_R14: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (in_write && in_ready));

    assert_hold_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !out_read && !cmd_go) |=>
            (out_ready && $stable(out_data) && $stable(out_flags)));

    assert_no_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && out_read && !out_flags[1] && !cmd_go) |=> out_ready);

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !cmd_go) |=> op_done);

    assert_fault_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_error |-> (!in_ready && !out_ready && !op_done));

    assert_clear_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && cmd_word[CLR_POS]) |=> (!op_done && !op_error && !in_ready));

    assert_one_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_ready));

endmodule

bind pktbuf_seq pktbuf_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STEP_W (STEP_W),
    .FLAG_W (FLAG_W),
    .CMD_W  (CMD_W)
) u_chk (.*);

// File: tb/pktbuf_seq_test.sv
// Self-checking bench: sweeps playback over many ranges, strides and
// consumer gaps, then exercises capture endings, faults and commands.
module pktbuf_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        cmd_go = 1'b0;
    logic        op_done, op_error, ram_en, ram_we;
    logic [8:0]  ram_addr;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = '0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_flags = '0;
    logic        in_write = 1'b0;
    logic        in_ready;
    logic [31:0] out_data;
    logic [3:0]  out_flags;
    logic        out_ready;
    logic        out_read = 1'b0;

    logic [31:0] mem [512];
    logic        pre_en = 1'b0;
    logic [8:0]  pre_a = '0;
    logic [31:0] pre_d = '0;
    int          we_total = 0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          ended = 1'b0;

    always #4 clk = ~clk;

    pktbuf_seq uut (
        .clk (clk), .rst_n (rst_n), .cmd_word (cmd_word), .cmd_go (cmd_go),
        .op_done (op_done), .op_error (op_error),
        .ram_en (ram_en), .ram_we (ram_we), .ram_addr (ram_addr),
        .ram_wdata (ram_wdata), .ram_rdata (ram_rdata),
        .in_data (in_data), .in_flags (in_flags), .in_write (in_write),
        .in_ready (in_ready),
        .out_data (out_data), .out_flags (out_flags), .out_ready (out_ready),
        .out_read (out_read)
    );

    // Bench RAM model with one cycle of read latency, plus a preload path.
    always @(posedge clk) begin
        if (pre_en) mem[pre_a] <= pre_d;
        else if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else        ram_rdata <= mem[ram_addr];
        end
        if (ram_we) we_total <= we_total + 1;
    end

    function automatic logic [31:0] pat(input int i);
        return 32'h5A00_0000 ^ (32'(i) * 32'h0001_0003);
    endfunction

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // Present a command for one cycle; returns at the negedge after the edge that took it.
    task automatic go_cmd(input int first, input int last, input int step,
                          input bit rd, input bit wr, input bit clr);
        @(negedge clk);
        cmd_word = {7'b0, clr, wr, rd, 4'(step), 9'(last), 9'(first)};
        cmd_go   = 1'b1;
        @(negedge clk);
        cmd_go   = 1'b0;
    endtask

    // Play a range out with a fixed gap between takes and check every cycle.
    task automatic read_pkt(input int first, input int last, input int step, input int gap);
        int eff, n, idx, gc, tmo;
        bit seen;
        eff  = (step == 0) ? 1 : step;
        n    = ((last - first) & 511) / eff + 1;
        idx  = 0; gc = 0; tmo = 0; seen = 1'b0;
        go_cmd(first, last, step, 1'b1, 1'b0, 1'b0);
        while (idx < n && tmo < 5000) begin
            int ea;
            ea = (first + idx * eff) & 511;
            if (out_ready) begin
                chk_eq("R2 word at expected line", out_data, mem[ea]);
                chk_eq("R4 tags on word", {28'b0, out_flags},
                       {30'b0, idx == n - 1, idx == 0});
                if (gc == 0) begin
                    out_read = 1'b1; idx++; gc = gap; seen = 1'b1;
                end else begin
                    out_read = 1'b0; gc--;   // R5: word must persist
                end
            end else begin
                if (gap == 0 && seen) chk_eq("R6 ready gap under back-to-back reads", 0, 1);
                out_read = 1'b0;
            end
            @(negedge clk);
            tmo++;
        end
        out_read = 1'b0;
        chk_eq("R2 playback finished before timeout", 32'(tmo < 5000), 1);
        chk_eq("R7 done after last word", op_done, 1);
        chk_eq("R7 ready low after last word", out_ready, 0);
    endtask

    // Offer nwords capture words; the word at eop_at carries an end tag,
    // the word at err_at carries both tags.
    task automatic write_pkt(input int first, input int last, input int step, input int nwords,
                             input int eop_at, input int err_at, input logic [31:0] base);
        go_cmd(first, last, step, 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < nwords; k++) begin
            chk_eq("R8 in_ready during capture", in_ready, 1);
            in_data  = base + 32'(k);
            in_flags = {2'b0, (k == eop_at) || (k == err_at), (k == 0) || (k == err_at)};
            in_write = 1'b1;
            @(negedge clk);
        end
        in_write = 1'b0;
        in_flags = '0;
    endtask

    // Watchdog.
    initial begin
        #(8 * 190000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int firsts [5] = '{0, 7, 260, 505, 511};
        int offs   [4] = '{0, 1, 5, 13};
        int w0;
        logic [31:0] keep_a, keep_b;

        repeat (3) @(negedge clk);
        chk_eq("R13 done low in reset", op_done, 0);
        chk_eq("R13 ram_en low in reset", ram_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R13 done after reset", op_done, 0);
        chk_eq("R13 error after reset", op_error, 0);
        chk_eq("R13 in_ready after reset", in_ready, 0);
        chk_eq("R13 out_ready after reset", out_ready, 0);
        chk_eq("R13 ram_en after reset", ram_en, 0);

        pre_en = 1'b1;
        for (int i = 0; i < 512; i++) begin
            pre_a = 9'(i); pre_d = pat(i);
            @(negedge clk);
        end
        pre_en = 1'b0;

        // R1 R2: playback sweep over start lines, lengths, strides and gaps.
        for (int fi = 0; fi < 5; fi++)
            for (int oi = 0; oi < 4; oi++)
                for (int s = 1; s <= 3; s++)
                    read_pkt(firsts[fi], (firsts[fi] + offs[oi]) & 511, s, (fi + oi + s) % 3);
        read_pkt(0, 511, 1, 0);
        read_pkt(505, 3, 1, 0);      // R2 wrap: eleven words
        read_pkt(5, 10, 1, 4);       // R5 long stalls
        read_pkt(5, 8, 0, 1);        // R3 stride 0 acts as 1
        read_pkt(2, 500, 15, 0);

        // R12: empty command after done leaves done set.
        go_cmd(0, 0, 0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk_eq("R12 done kept after empty go", op_done, 1);

        // R8 R14: full capture of six lines.
        keep_a = mem[9]; keep_b = mem[16]; w0 = we_total;
        write_pkt(10, 15, 1, 6, -1, -1, 32'h1000);
        for (int j = 0; j < 6; j++) chk_eq("R8 captured line", mem[10 + j], 32'h1000 + 32'(j));
        chk_eq("R8 line below range kept", mem[9], keep_a);
        chk_eq("R8 line above range kept", mem[16], keep_b);
        chk_eq("R8 done after end line", op_done, 1);
        chk_eq("R8 in_ready dropped", in_ready, 0);
        chk_eq("R14 write count", 32'(we_total - w0), 6);

        // R2 R8: wrapping capture with stride 2 touches 508,510,0,2,4.
        keep_a = mem[509]; keep_b = mem[1];
        write_pkt(508, 4, 2, 5, -1, -1, 32'h2000);
        for (int j = 0; j < 5; j++)
            chk_eq("R2 wrapped capture line", mem[(508 + 2 * j) & 511], 32'h2000 + 32'(j));
        chk_eq("R2 skipped line 509 kept", mem[509], keep_a);
        chk_eq("R2 skipped line 1 kept", mem[1], keep_b);
        chk_eq("R8 done after wrapped capture", op_done, 1);
        read_pkt(508, 4, 2, 0);

        // R9: end tag on the fourth word stops the capture early.
        keep_a = mem[31]; w0 = we_total;
        write_pkt(27, 40, 1, 4, 3, -1, 32'h3000);
        for (int j = 0; j < 4; j++) chk_eq("R9 stored before end tag", mem[27 + j], 32'h3000 + 32'(j));
        chk_eq("R9 next line kept", mem[31], keep_a);
        chk_eq("R9 done on end tag", op_done, 1);
        chk_eq("R9 in_ready dropped", in_ready, 0);
        chk_eq("R14 write count early end", 32'(we_total - w0), 4);

        // R10: both tags on the fourth word abort with error.
        keep_a = mem[63]; w0 = we_total;
        write_pkt(60, 70, 1, 4, -1, 3, 32'h4000);
        for (int j = 0; j < 3; j++) chk_eq("R10 stored before fault", mem[60 + j], 32'h4000 + 32'(j));
        chk_eq("R10 faulty word not stored", mem[63], keep_a);
        chk_eq("R10 error raised", op_error, 1);
        chk_eq("R10 done low on fault", op_done, 0);
        chk_eq("R10 in_ready dropped", in_ready, 0);
        chk_eq("R14 write count on fault", 32'(we_total - w0), 3);

        go_cmd(0, 0, 0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk_eq("R12 error kept after empty go", op_error, 1);

        go_cmd(0, 0, 0, 1'b0, 1'b0, 1'b1);
        chk_eq("R11 error cleared", op_error, 0);
        chk_eq("R11 done cleared", op_done, 0);
        chk_eq("R11 in_ready low", in_ready, 0);

        // R1: single-word packet with both tags on the first word is valid.
        write_pkt(80, 90, 1, 1, -1, 0, 32'h5000);
        chk_eq("R10 first word with both tags stored", mem[80], 32'h5000);
        chk_eq("R9 single-word packet done", op_done, 1);

        // R1: capture wins over playback.
        go_cmd(100, 101, 1, 1'b1, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk_eq("R1 capture wins over playback", in_ready, 1);
        chk_eq("R1 no playback word", out_ready, 0);
        // R1: clear wins over playback.
        go_cmd(100, 101, 1, 1'b1, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk_eq("R1 clear wins: no playback", out_ready, 0);
        chk_eq("R11 idle after clear", in_ready, 0);
        chk_eq("R11 done low after clear", op_done, 0);

        finish_run();
    end

endmodule